// File: doc/BRIEF.md
# Replay-Based Fault Classifier

This controller sits beside the error-symptom detectors of a multicore processor and decides what kind of fault a symptom points to. When any symptom line fires while the controller is idle, it asks the recovery machinery to restore the last checkpoint and re-execute on the core that raised the symptom. It then watches a window of retired instructions. A clean window means the fault did not repeat. That points to a transient hardware upset or a non-deterministic software fault.

If the symptom returns on the original core, a second restore is requested, this time steering re-execution to the next enabled core. If that run is clean, the original core carries a permanent defect, and a sticky disable request is raised for it. A symptom that follows the work to the other core indicates a deterministic software bug. When no other core is enabled, the outcome is reported as undiagnosable. Every outcome is presented as a one-hot code with a single-cycle valid strobe, after which the controller returns to idle.

Top module: `replay_diag_ctrl`

## Requirements
- R1: After reset, `rb_req_o`, `cls_valid_o`, `cls_code_o` and `dis_mask_o` are all zero.
- R2: While idle, any asserted bit of `sym_i` (bit 0 misaligned access trap, bit 1 error-state entry, bit 2 watchdog reset, bit 3 hang timeout) makes `rb_req_o` high from the next cycle, with `tgt_core_o` equal to the `sym_core_i` value sampled with the symptom.
- R3: `rb_req_o` stays high until `rb_ack_i` is sampled high, and is low in the cycle after that acknowledge.
- R4: A replay is clean once `win_len_i` cycles with `retire_i` high have been sampled after the acknowledge with no symptom. A clean first replay reports code 4'b0001 (transient / non-deterministic).
- R5: A symptom during the first replay raises a second rollback with `tgt_core_o` set to the next enabled core index above the original, wrapping past the top index to 0, and skipping disabled cores.
- R6: A clean second replay reports code 4'b0010 (permanent core defect) and sets bit `orig` of `dis_mask_o`. Once set, that bit stays set until reset, and no other outcome sets any bit.
- R7: A symptom during the second replay reports code 4'b0100 (deterministic software bug).
- R8: A symptom during the first replay, when no core other than the original is enabled in `core_en_i`, reports code 4'b1000 (undiagnosable) without a second rollback.
- R9: Symptoms that arrive while a rollback request is pending are ignored, and so are symptoms that arrive in the acknowledge cycle.
- R10: `cls_valid_o` is high for exactly one cycle per diagnosis, with exactly one bit of `cls_code_o` set. `cls_code_o` is zero whenever `cls_valid_o` is low. A new symptom is accepted from the cycle after the report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_i | input | NSYM | Symptom lines |
| sym_core_i | input | CORE_W | Core that raised the symptom |
| core_en_i | input | NUM_CORES | Cores available as replay targets |
| win_len_i | input | CNT_W | Retired instructions in a clean window |
| retire_i | input | 1 | One instruction retired this cycle |
| rb_req_o | output | 1 | Rollback request |
| rb_ack_i | input | 1 | Rollback acknowledge |
| tgt_core_o | output | CORE_W | Core selected for the replay |
| cls_valid_o | output | 1 | Diagnosis valid strobe |
| cls_code_o | output | 4 | One-hot diagnosis code |
| dis_mask_o | output | NUM_CORES | Sticky per-core disable requests |

## Verification
The bench builds the block with four cores, four symptom lines and an 8-bit window counter, and drives a window length of 3. With four cores, the wrap from index 3 back to 0 and a skip over a disabled middle core are both reachable, as is a mask in which only the original core is enabled. The short window lets each replay outcome, including several permanent defects accumulating in the disable mask, be reached within a few dozen cycles.

// File: rtl/replay_diag_pkg.sv
package replay_diag_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RB_SAME,
    ST_OBS_SAME,
    ST_RB_ALT,
    ST_OBS_ALT
  } diag_state_e;

  localparam int CLS_W        = 4;
  localparam int CLS_TRANSIENT = 0;
  localparam int CLS_PERMANENT = 1;
  localparam int CLS_SOFTWARE  = 2;
  localparam int CLS_UNKNOWN   = 3;
endpackage

// File: rtl/retire_window.sv
module retire_window #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             active_i,
  input  logic             retire_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   sum;
  logic             step;

  assign step   = active_i & retire_i;
  assign sum    = {1'b0, cnt_q} + {{CNT_W{1'b0}}, step};
  assign done_o = active_i && (sum >= {1'b0, limit_i});

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (step && !done_o) begin
      cnt_d = sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/alt_core_pick.sv
module alt_core_pick #(
  parameter int NUM_CORES = 4,
  localparam int CORE_W = $clog2(NUM_CORES)
) (
  input  logic [CORE_W-1:0]    orig_i,
  input  logic [NUM_CORES-1:0] enable_i,
  output logic [CORE_W-1:0]    alt_o,
  output logic                 found_o
);
  logic [CORE_W:0] cand [NUM_CORES];

  for (genvar k = 1; k < NUM_CORES; k++) begin : g_cand
    logic [CORE_W:0] raw;
    assign raw = {1'b0, orig_i} + (CORE_W+1)'(k);
    assign cand[k] = (raw >= (CORE_W+1)'(NUM_CORES)) ? raw - (CORE_W+1)'(NUM_CORES) : raw;
  end
  assign cand[0] = {1'b0, orig_i};

  always_comb begin
    alt_o   = orig_i;
    found_o = 1'b0;
    for (int k = NUM_CORES - 1; k >= 1; k--) begin
      if (enable_i[cand[k][CORE_W-1:0]]) begin
        alt_o   = cand[k][CORE_W-1:0];
        found_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/replay_diag_ctrl.sv
module replay_diag_ctrl
  import replay_diag_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NSYM      = 4,
  parameter int CNT_W     = 16,
  localparam int CORE_W   = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSYM-1:0]      sym_i,
  input  logic [CORE_W-1:0]    sym_core_i,
  input  logic [NUM_CORES-1:0] core_en_i,
  input  logic [CNT_W-1:0]     win_len_i,
  input  logic                 retire_i,
  output logic                 rb_req_o,
  input  logic                 rb_ack_i,
  output logic [CORE_W-1:0]    tgt_core_o,
  output logic                 cls_valid_o,
  output logic [CLS_W-1:0]     cls_code_o,
  output logic [NUM_CORES-1:0] dis_mask_o
);
  diag_state_e          state_q, state_d;
  logic [CORE_W-1:0]    orig_q, orig_d, tgt_q, tgt_d;
  logic                 vld_q, vld_d;
  logic [CLS_W-1:0]     code_q, code_d;
  logic [NUM_CORES-1:0] dis_q, dis_d;
  logic                 any_sym, win_clr, win_act, win_done;
  logic [CORE_W-1:0]    alt_core;
  logic                 alt_ok;

  assign any_sym = |sym_i;
  assign win_act = (state_q == ST_OBS_SAME) || (state_q == ST_OBS_ALT);

  retire_window #(.CNT_W(CNT_W)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (win_clr),
    .active_i (win_act),
    .retire_i (retire_i),
    .limit_i  (win_len_i),
    .done_o   (win_done)
  );

  alt_core_pick #(.NUM_CORES(NUM_CORES)) u_pick (
    .orig_i   (orig_q),
    .enable_i (core_en_i),
    .alt_o    (alt_core),
    .found_o  (alt_ok)
  );

  always_comb begin
    state_d = state_q;
    orig_d  = orig_q;
    tgt_d   = tgt_q;
    vld_d   = 1'b0;
    code_d  = '0;
    dis_d   = dis_q;
    win_clr = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (any_sym) begin
          orig_d  = sym_core_i;
          tgt_d   = sym_core_i;
          state_d = ST_RB_SAME;
        end
      end
      ST_RB_SAME: begin
        if (rb_ack_i) begin
          win_clr = 1'b1;
          state_d = ST_OBS_SAME;
        end
      end
      ST_OBS_SAME: begin
        if (any_sym) begin
          if (alt_ok) begin
            tgt_d   = alt_core;
            state_d = ST_RB_ALT;
          end else begin
            vld_d                 = 1'b1;
            code_d[CLS_UNKNOWN]   = 1'b1;
            state_d               = ST_IDLE;
          end
        end else if (win_done) begin
          vld_d                 = 1'b1;
          code_d[CLS_TRANSIENT] = 1'b1;
          state_d               = ST_IDLE;
        end
      end
      ST_RB_ALT: begin
        if (rb_ack_i) begin
          win_clr = 1'b1;
          state_d = ST_OBS_ALT;
        end
      end
      ST_OBS_ALT: begin
        if (any_sym) begin
          vld_d                = 1'b1;
          code_d[CLS_SOFTWARE] = 1'b1;
          state_d              = ST_IDLE;
        end else if (win_done) begin
          vld_d                 = 1'b1;
          code_d[CLS_PERMANENT] = 1'b1;
          dis_d[orig_q]         = 1'b1;
          state_d               = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      orig_q  <= '0;
      tgt_q   <= '0;
      vld_q   <= 1'b0;
      code_q  <= '0;
      dis_q   <= '0;
    end else begin
      state_q <= state_d;
      orig_q  <= orig_d;
      tgt_q   <= tgt_d;
      vld_q   <= vld_d;
      code_q  <= code_d;
      dis_q   <= dis_d;
    end
  end

  assign rb_req_o    = (state_q == ST_RB_SAME) || (state_q == ST_RB_ALT);
  assign tgt_core_o  = tgt_q;
  assign cls_valid_o = vld_q;
  assign cls_code_o  = code_q;
  assign dis_mask_o  = dis_q;
endmodule

// File: rtl/replay_diag_checker.sv
module replay_diag_checker #(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rb_req_o,
  input logic                 rb_ack_i,
  input logic                 cls_valid_o,
  input logic [3:0]           cls_code_o,
  input logic [NUM_CORES-1:0] dis_mask_o,
  input logic [CORE_W-1:0]    orig_q
);
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rb_req_o && !rb_ack_i |=> rb_req_o);

  p_req_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rb_req_o && rb_ack_i |=> !rb_req_o);

  p_code_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cls_valid_o |-> $countones(cls_code_o) == 1);

  p_code_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cls_valid_o |-> cls_code_o == 4'b0000);

  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cls_valid_o |=> !cls_valid_o);

  p_mask_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dis_mask_o & $past(dis_mask_o)) == $past(dis_mask_o)));

  p_perm_disables_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cls_valid_o && cls_code_o[1] |-> dis_mask_o[orig_q]);

  p_mask_only_perm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_mask_o != $past(dis_mask_o)) |-> cls_valid_o && cls_code_o[1]);
endmodule

bind replay_diag_ctrl replay_diag_checker #(
  .NUM_CORES (NUM_CORES),
  .CORE_W    (CORE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rb_req_o    (rb_req_o),
  .rb_ack_i    (rb_ack_i),
  .cls_valid_o (cls_valid_o),
  .cls_code_o  (cls_code_o),
  .dis_mask_o  (dis_mask_o),
  .orig_q      (orig_q)
);

// File: tb/tb_replay_diag_ctrl.sv
`timescale 1ns/1ps
module tb_replay_diag_ctrl;
  localparam int NC = 4;
  localparam int NS = 4;
  localparam int CW = 8;
  localparam int WIN = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] sym;
  logic [1:0]    sym_core;
  logic [NC-1:0] core_en;
  logic [CW-1:0] win_len;
  logic          retire;
  logic          rb_req;
  logic          rb_ack;
  logic [1:0]    tgt_core;
  logic          cls_valid;
  logic [3:0]    cls_code;
  logic [NC-1:0] dis_mask;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  replay_diag_ctrl #(.NUM_CORES(NC), .NSYM(NS), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .sym_i(sym), .sym_core_i(sym_core),
    .core_en_i(core_en), .win_len_i(win_len), .retire_i(retire),
    .rb_req_o(rb_req), .rb_ack_i(rb_ack), .tgt_core_o(tgt_core),
    .cls_valid_o(cls_valid), .cls_code_o(cls_code), .dis_mask_o(dis_mask)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic raise(input logic [1:0] core, input logic [NS-1:0] bits);
    sym = bits; sym_core = core; retire = 1'b0;
    step();
    sym = '0;
  endtask

  task automatic grant(input logic [1:0] exp_tgt, input int hold, input logic [NS-1:0] noise);
    chk(rb_req == 1'b1, "R2 request raised", 32'(rb_req), 1);
    chk(tgt_core == exp_tgt, "R5 target core", 32'(tgt_core), 32'(exp_tgt));
    for (int i = 0; i < hold; i++) begin
      sym = noise;
      step();
      chk(rb_req == 1'b1, "R3 request held", 32'(rb_req), 1);
    end
    sym = noise;
    rb_ack = 1'b1;
    step();
    rb_ack = 1'b0; sym = '0;
    chk(rb_req == 1'b0, "R3 request dropped", 32'(rb_req), 0);
  endtask

  task automatic clean_window();
    for (int i = 0; i < WIN; i++) begin
      if (i == WIN - 1) chk(cls_valid == 1'b0, "R4 no early result", 32'(cls_valid), 0);
      retire = 1'b1;
      step();
    end
    retire = 1'b0;
  endtask

  task automatic replay_sym(input logic [NS-1:0] bits);
    retire = 1'b1; step();
    sym = bits; retire = 1'b0; step();
    sym = '0;
  endtask

  task automatic expect_result(input logic [3:0] code, input string tag);
    chk(cls_valid == 1'b1, {tag, " valid"}, 32'(cls_valid), 1);
    chk(cls_code == code, {tag, " code"}, 32'(cls_code), 32'(code));
    step();
    chk(cls_valid == 1'b0, "R10 single pulse", 32'(cls_valid), 0);
    chk(cls_code == 4'b0000, "R10 code cleared", 32'(cls_code), 0);
    chk(rb_req == 1'b0, "R10 back to idle", 32'(rb_req), 0);
  endtask

  task automatic t_reset();
    chk(rb_req == 1'b0, "R1 req", 32'(rb_req), 0);
    chk(cls_valid == 1'b0, "R1 valid", 32'(cls_valid), 0);
    chk(cls_code == 4'b0000, "R1 code", 32'(cls_code), 0);
    chk(dis_mask == 4'b0000, "R1 mask", 32'(dis_mask), 0);
  endtask

  task automatic t_transient();
    core_en = 4'b1111;
    raise(2'd2, 4'b0001);
    grant(2'd2, 1, 4'b0000);
    clean_window();
    expect_result(4'b0001, "R4 transient");
  endtask

  task automatic t_perm_skip();
    core_en = 4'b1011;
    raise(2'd1, 4'b0010);
    grant(2'd1, 0, 4'b0000);
    replay_sym(4'b0100);
    grant(2'd3, 0, 4'b0000);
    clean_window();
    expect_result(4'b0010, "R6 permanent");
    chk(dis_mask == 4'b0010, "R6 mask bit1", 32'(dis_mask), 32'h2);
  endtask

  task automatic t_perm_wrap();
    core_en = 4'b1011;
    raise(2'd3, 4'b1000);
    grant(2'd3, 0, 4'b0000);
    replay_sym(4'b0001);
    grant(2'd0, 0, 4'b0000);
    clean_window();
    expect_result(4'b0010, "R5 wrap permanent");
    chk(dis_mask == 4'b1010, "R6 sticky mask", 32'(dis_mask), 32'hA);
  endtask

  task automatic t_software();
    core_en = 4'b1111;
    raise(2'd0, 4'b1000);
    grant(2'd0, 0, 4'b0000);
    replay_sym(4'b1000);
    grant(2'd1, 0, 4'b0000);
    replay_sym(4'b0010);
    expect_result(4'b0100, "R7 software");
    chk(dis_mask == 4'b1010, "R6 mask unchanged by R7", 32'(dis_mask), 32'hA);
  endtask

  task automatic t_undiag();
    core_en = 4'b0100;
    raise(2'd2, 4'b0100);
    grant(2'd2, 0, 4'b0000);
    replay_sym(4'b0001);
    chk(rb_req == 1'b0, "R8 no second rollback", 32'(rb_req), 0);
    expect_result(4'b1000, "R8 undiagnosable");
    chk(dis_mask == 4'b1010, "R8 mask unchanged", 32'(dis_mask), 32'hA);
  endtask

  task automatic t_ignore();
    core_en = 4'b1111;
    raise(2'd0, 4'b0001);
    grant(2'd0, 3, 4'b1111);
    clean_window();
    expect_result(4'b0001, "R9 noise during first rollback");
    raise(2'd0, 4'b0001);
    grant(2'd0, 0, 4'b0000);
    replay_sym(4'b0001);
    grant(2'd1, 2, 4'b0110);
    clean_window();
    expect_result(4'b0010, "R9 noise during second rollback");
    chk(dis_mask == 4'b1011, "R9 mask", 32'(dis_mask), 32'hB);
  endtask

  task automatic t_back_to_back();
    core_en = 4'b1111;
    raise(2'd3, 4'b0010);
    grant(2'd3, 0, 4'b0000);
    retire = 1'b1;
    for (int i = 0; i < WIN; i++) step();
    retire = 1'b0;
    chk(cls_valid == 1'b1, "R10 result before restart", 32'(cls_valid), 1);
    raise(2'd1, 4'b0001);
    chk(rb_req == 1'b1, "R10 new symptom accepted", 32'(rb_req), 1);
    chk(tgt_core == 2'd1, "R2 new target", 32'(tgt_core), 1);
    grant(2'd1, 0, 4'b0000);
    clean_window();
    expect_result(4'b0001, "R10 second diagnosis");
  endtask

  initial begin
    sym = '0; sym_core = '0; core_en = 4'b1111; win_len = CW'(WIN);
    retire = 1'b0; rb_ack = 1'b0; rst_n = 1'b0;
    repeat (3) step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_transient();
    t_perm_skip();
    t_perm_wrap();
    t_software();
    t_undiag();
    t_ignore();
    t_back_to_back();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule